// File: doc/BRIEF.md
# Warp Instruction Issue Scheduler

This block sits between an instruction fetch stage and a set of execution pipes in a many-warp processor core. It keeps one buffered instruction per resident warp. A fetch port may load one instruction per cycle into the slot of any warp whose slot is empty. Each buffered instruction carries a destination register, two source registers, a target pipe and an opaque tag. A per-warp register scoreboard records which destinations still wait for a result. An instruction becomes eligible only when none of its three registers is pending and its target pipe can accept new work.

Every cycle the scheduler issues at most one eligible instruction. It searches the warps in rotating order, starting at the warp just after the one that issued last. A warp stalled on a long-latency result therefore never holds back the others, and moving from one warp to another costs no cycles. Issuing marks the destination as pending. A writeback port clears the mark again. Each execution pipe stays occupied for a fixed number of cycles after it accepts an instruction.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset, `issue_valid` is 0, every bit of `slot_free` is 1, no register is pending, every pipe is free, and the rotating search begins at warp 0.
- R2: A fetch to a warp index below NUM_WARPS whose slot is empty loads that slot at the clock edge, and `slot_free` for that warp reads 0 from the next cycle. A fetch to an occupied slot that does not issue in that cycle is ignored, and the buffered instruction keeps its tag. A fetch to a warp index of NUM_WARPS or above is ignored.
- R3: The issue outputs are registered. An instruction chosen in cycle N appears on `issue_*` after the edge that ends cycle N, with its warp, destination, sources, pipe and tag unchanged. At most one instruction issues per cycle.
- R4: An instruction whose source register (either one) is pending for its own warp is not issued. A writeback (`wb_valid`, `wb_warp`, `wb_reg`) clears only that warp's bit, and the cleared bit counts from the following cycle. A writeback to another warp, or to a warp index of NUM_WARPS or above, has no effect.
- R5: An instruction whose destination register is still pending for its warp waits until that bit clears (write-after-write).
- R6: Issuing an instruction marks its destination register pending for its warp. If a writeback to the same bit arrives in the same cycle, the mark wins.
- R7: Among eligible warps, the choice is the first one found at or after the rotating pointer in ascending order, wrapping at NUM_WARPS. After an issue the pointer moves to the warp after the issued one.
- R8: When a pipe accepts an instruction in cycle N, no instruction for that pipe is issued in cycles N+1 to N+PIPE_OCC-1. Another pipe may issue during that time. The pipe number is the `fetch_pipe` field.
- R9: Whenever at least one warp is eligible, an instruction is issued in that cycle, whatever state the other warps are in.
- R10: A slot is freed in the cycle its instruction is chosen, and a fetch to that same warp in that cycle is accepted into the slot.
- R11: In a cycle with no eligible warp, `issue_valid` is 0 after the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch port carries an instruction |
| fetch_warp | input | WID_W | Warp slot the instruction is for |
| fetch_dst | input | RID_W | Destination register |
| fetch_src_a | input | RID_W | First source register |
| fetch_src_b | input | RID_W | Second source register |
| fetch_pipe | input | PID_W | Target execution pipe |
| fetch_tag | input | TAG_W | Opaque payload passed through to issue |
| slot_free | output | NUM_WARPS | One bit per warp, 1 when the slot is empty |
| wb_valid | input | 1 | Writeback completes a register |
| wb_warp | input | WID_W | Warp of the writeback |
| wb_reg | input | RID_W | Register that was written |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_warp | output | WID_W | Warp of the issued instruction |
| issue_dst | output | RID_W | Destination register of the issued instruction |
| issue_src_a | output | RID_W | First source register |
| issue_src_b | output | RID_W | Second source register |
| issue_pipe | output | PID_W | Target pipe |
| issue_tag | output | TAG_W | Payload of the issued instruction |

## Verification
The bench keeps warps stuck on pending sources and destinations while it fills other slots. A design that let one stalled warp block the search, or that forgot the write-after-write check, would then issue in the wrong order or issue too early. Pipe occupancy is pushed by queuing several instructions for one pipe while the other pipe stays free. A wrong countdown shows up as an issue one cycle early or late. Further corner cases are a refill of the slot that is issuing in the same cycle, a fetch into an occupied slot, and writebacks aimed at the wrong warp or at an out-of-range warp. A design that dropped the refill, overwrote the slot or cleared the wrong bit shows a tag that differs from the expected one, or an issue at the wrong time.

// File: rtl/wsched_pkg.sv
package wsched_pkg;

    // Add an offset to an index and wrap it into the range [0, modulus).
    function automatic int wrap_add(input int base, input int off, input int modulus);
        int sum;
        sum = base + off;
        if (sum >= modulus) begin
            sum = sum - modulus;
        end
        return sum;
    endfunction

    // Width helper that never returns zero.
    function automatic int safe_bits(input int count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

endpackage

// File: rtl/wsched_scoreboard.sv
module wsched_scoreboard #(
    parameter int NUM_WARPS = 24,
    parameter int NUM_REGS  = 32,
    parameter int WID_W     = 5,
    parameter int RID_W     = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        set_en,
    input  logic [WID_W-1:0]            set_warp,
    input  logic [RID_W-1:0]            set_reg,
    input  logic                        clr_en,
    input  logic [WID_W-1:0]            clr_warp,
    input  logic [RID_W-1:0]            clr_reg,
    input  logic [NUM_WARPS*RID_W-1:0]  chk_dst,
    input  logic [NUM_WARPS*RID_W-1:0]  chk_src_a,
    input  logic [NUM_WARPS*RID_W-1:0]  chk_src_b,
    output logic [NUM_WARPS-1:0]        hazard
);

    typedef struct packed {
        logic [NUM_WARPS-1:0][NUM_REGS-1:0] pend;
    } sb_state_t;

    sb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_en && (int'(clr_warp) < NUM_WARPS) && (int'(clr_reg) < NUM_REGS)) begin
            st_d.pend[clr_warp][clr_reg] = 1'b0;
        end
        // the mark for a newly issued destination wins over a same-cycle clear
        if (set_en) begin
            st_d.pend[set_warp][set_reg] = 1'b1;
        end
    end

    always_comb begin
        logic [RID_W-1:0] rd, ra, rb;
        for (int w = 0; w < NUM_WARPS; w++) begin
            rd = chk_dst[w*RID_W +: RID_W];
            ra = chk_src_a[w*RID_W +: RID_W];
            rb = chk_src_b[w*RID_W +: RID_W];
            hazard[w] = st_q.pend[w][rd] | st_q.pend[w][ra] | st_q.pend[w][rb];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5
    waw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> !st_q.pend[set_warp][set_reg]);

endmodule

// File: rtl/wsched_rr_pick.sv
module wsched_rr_pick #(
    parameter int NUM_WARPS = 24,
    parameter int WID_W     = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_WARPS-1:0] eligible,
    output logic                 grant_valid,
    output logic [WID_W-1:0]     grant_idx
);

    typedef struct packed {
        logic [WID_W-1:0] ptr;
    } rr_state_t;

    rr_state_t st_d, st_q;

    always_comb begin
        int idx;
        grant_valid = 1'b0;
        grant_idx   = '0;
        for (int k = 0; k < NUM_WARPS; k++) begin
            idx = wsched_pkg::wrap_add(int'(st_q.ptr), k, NUM_WARPS);
            if (!grant_valid && eligible[idx]) begin
                grant_valid = 1'b1;
                grant_idx   = WID_W'(idx);
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (grant_valid) begin
            st_d.ptr = WID_W'(wsched_pkg::wrap_add(int'(grant_idx), 1, NUM_WARPS));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7
    grant_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> eligible[grant_idx]);

    // R9
    work_cons_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|eligible) |-> grant_valid);

    // R11
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eligible == '0) |-> !grant_valid);

endmodule

// File: rtl/wsched_pipe_timer.sv
module wsched_pipe_timer #(
    parameter int NUM_PIPES = 2,
    parameter int PID_W     = 1,
    parameter int PIPE_OCC  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue_en,
    input  logic [PID_W-1:0]     issue_pipe,
    output logic [NUM_PIPES-1:0] busy
);

    localparam int CNT_W = wsched_pkg::safe_bits(PIPE_OCC);

    typedef struct packed {
        logic [NUM_PIPES-1:0][CNT_W-1:0] cnt;
    } pt_state_t;

    pt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int p = 0; p < NUM_PIPES; p++) begin
            if (st_q.cnt[p] != '0) begin
                st_d.cnt[p] = st_q.cnt[p] - 1'b1;
            end
            if (issue_en && (int'(issue_pipe) == p)) begin
                st_d.cnt[p] = CNT_W'(PIPE_OCC - 1);
            end
        end
    end

    for (genvar gp = 0; gp < NUM_PIPES; gp++) begin : g_busy
        assign busy[gp] = (st_q.cnt[gp] != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R8
    pipe_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_en |-> !busy[issue_pipe]);

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
    parameter int NUM_WARPS = 24,
    parameter int NUM_REGS  = 32,
    parameter int NUM_PIPES = 2,
    parameter int PIPE_OCC  = 4,
    parameter int TAG_W     = 8,
    localparam int WID_W    = wsched_pkg::safe_bits(NUM_WARPS),
    localparam int RID_W    = wsched_pkg::safe_bits(NUM_REGS),
    localparam int PID_W    = wsched_pkg::safe_bits(NUM_PIPES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fetch_valid,
    input  logic [WID_W-1:0]     fetch_warp,
    input  logic [RID_W-1:0]     fetch_dst,
    input  logic [RID_W-1:0]     fetch_src_a,
    input  logic [RID_W-1:0]     fetch_src_b,
    input  logic [PID_W-1:0]     fetch_pipe,
    input  logic [TAG_W-1:0]     fetch_tag,
    output logic [NUM_WARPS-1:0] slot_free,
    input  logic                 wb_valid,
    input  logic [WID_W-1:0]     wb_warp,
    input  logic [RID_W-1:0]     wb_reg,
    output logic                 issue_valid,
    output logic [WID_W-1:0]     issue_warp,
    output logic [RID_W-1:0]     issue_dst,
    output logic [RID_W-1:0]     issue_src_a,
    output logic [RID_W-1:0]     issue_src_b,
    output logic [PID_W-1:0]     issue_pipe,
    output logic [TAG_W-1:0]     issue_tag
);

    typedef struct packed {
        logic             vld;
        logic [RID_W-1:0] dst;
        logic [RID_W-1:0] sa;
        logic [RID_W-1:0] sb;
        logic [PID_W-1:0] pipe;
        logic [TAG_W-1:0] tag;
    } slot_t;

    typedef struct packed {
        slot_t [NUM_WARPS-1:0] slots;
        logic                  iss_vld;
        logic [WID_W-1:0]      iss_warp;
        slot_t                 iss;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [NUM_WARPS-1:0]       hazard;
    logic [NUM_WARPS-1:0]       pipe_blocked;
    logic [NUM_WARPS-1:0]       eligible;
    logic [NUM_PIPES-1:0]       busy;
    logic                       grant_valid;
    logic [WID_W-1:0]           grant_idx;
    logic [RID_W-1:0]           grant_dst;
    logic [PID_W-1:0]           grant_pipe;
    logic                       fetch_take;
    logic [NUM_WARPS*RID_W-1:0] dst_flat, sa_flat, sb_flat;

    for (genvar gw = 0; gw < NUM_WARPS; gw++) begin : g_flat
        assign dst_flat[gw*RID_W +: RID_W] = st_q.slots[gw].dst;
        assign sa_flat[gw*RID_W +: RID_W]  = st_q.slots[gw].sa;
        assign sb_flat[gw*RID_W +: RID_W]  = st_q.slots[gw].sb;
        assign pipe_blocked[gw] = (int'(st_q.slots[gw].pipe) >= NUM_PIPES)
                                  || busy[st_q.slots[gw].pipe];
        assign eligible[gw] = st_q.slots[gw].vld & ~hazard[gw] & ~pipe_blocked[gw];
        assign slot_free[gw] = ~st_q.slots[gw].vld;
    end

    assign grant_dst  = st_q.slots[grant_idx].dst;
    assign grant_pipe = st_q.slots[grant_idx].pipe;

    wsched_scoreboard #(
        .NUM_WARPS (NUM_WARPS),
        .NUM_REGS  (NUM_REGS),
        .WID_W     (WID_W),
        .RID_W     (RID_W)
    ) u_sb (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (grant_valid),
        .set_warp  (grant_idx),
        .set_reg   (grant_dst),
        .clr_en    (wb_valid),
        .clr_warp  (wb_warp),
        .clr_reg   (wb_reg),
        .chk_dst   (dst_flat),
        .chk_src_a (sa_flat),
        .chk_src_b (sb_flat),
        .hazard    (hazard)
    );

    wsched_rr_pick #(
        .NUM_WARPS (NUM_WARPS),
        .WID_W     (WID_W)
    ) u_pick (
        .clk         (clk),
        .rst_n       (rst_n),
        .eligible    (eligible),
        .grant_valid (grant_valid),
        .grant_idx   (grant_idx)
    );

    wsched_pipe_timer #(
        .NUM_PIPES (NUM_PIPES),
        .PID_W     (PID_W),
        .PIPE_OCC  (PIPE_OCC)
    ) u_pipes (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue_en   (grant_valid),
        .issue_pipe (grant_pipe),
        .busy       (busy)
    );

    always_comb begin
        st_d       = st_q;
        fetch_take = 1'b0;

        st_d.iss_vld = grant_valid;
        if (grant_valid) begin
            st_d.iss_warp = grant_idx;
            st_d.iss      = st_q.slots[grant_idx];
            st_d.slots[grant_idx].vld = 1'b0;
        end

        if (fetch_valid && (int'(fetch_warp) < NUM_WARPS)) begin
            if (!st_q.slots[fetch_warp].vld || (grant_valid && (grant_idx == fetch_warp))) begin
                fetch_take = 1'b1;
            end
        end

        if (fetch_take) begin
            st_d.slots[fetch_warp].vld  = 1'b1;
            st_d.slots[fetch_warp].dst  = fetch_dst;
            st_d.slots[fetch_warp].sa   = fetch_src_a;
            st_d.slots[fetch_warp].sb   = fetch_src_b;
            st_d.slots[fetch_warp].pipe = fetch_pipe;
            st_d.slots[fetch_warp].tag  = fetch_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign issue_valid = st_q.iss_vld;
    assign issue_warp  = st_q.iss_warp;
    assign issue_dst   = st_q.iss.dst;
    assign issue_src_a = st_q.iss.sa;
    assign issue_src_b = st_q.iss.sb;
    assign issue_pipe  = st_q.iss.pipe;
    assign issue_tag   = st_q.iss.tag;

    // R2
    fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_take |=> !slot_free[$past(fetch_warp)]);

    // R10
    refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !(fetch_take && (fetch_warp == grant_idx))) |=> slot_free[$past(grant_idx)]);

endmodule

// File: tb/warp_issue_sched_bench.sv
`timescale 1ns/1ps
module warp_issue_sched_bench;

    localparam int NW   = 24;
    localparam int NR   = 32;
    localparam int NP   = 2;
    localparam int OCC  = 4;
    localparam int TW   = 8;
    localparam int WW   = 5;
    localparam int RW   = 5;
    localparam int PW   = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fetch_valid = 1'b0;
    logic [WW-1:0] fetch_warp = '0;
    logic [RW-1:0] fetch_dst = '0, fetch_src_a = '0, fetch_src_b = '0;
    logic [PW-1:0] fetch_pipe = '0;
    logic [TW-1:0] fetch_tag = '0;
    logic [NW-1:0] slot_free;
    logic          wb_valid = 1'b0;
    logic [WW-1:0] wb_warp = '0;
    logic [RW-1:0] wb_reg = '0;
    logic          issue_valid;
    logic [WW-1:0] issue_warp;
    logic [RW-1:0] issue_dst, issue_src_a, issue_src_b;
    logic [PW-1:0] issue_pipe;
    logic [TW-1:0] issue_tag;

    always #2 clk = ~clk;

    warp_issue_sched u_warp_issue_sched (
        .clk (clk), .rst_n (rst_n),
        .fetch_valid (fetch_valid), .fetch_warp (fetch_warp), .fetch_dst (fetch_dst),
        .fetch_src_a (fetch_src_a), .fetch_src_b (fetch_src_b), .fetch_pipe (fetch_pipe),
        .fetch_tag (fetch_tag), .slot_free (slot_free),
        .wb_valid (wb_valid), .wb_warp (wb_warp), .wb_reg (wb_reg),
        .issue_valid (issue_valid), .issue_warp (issue_warp), .issue_dst (issue_dst),
        .issue_src_a (issue_src_a), .issue_src_b (issue_src_b), .issue_pipe (issue_pipe),
        .issue_tag (issue_tag)
    );

    // reference state
    bit m_v [NW];
    int m_d [NW], m_a [NW], m_b [NW], m_p [NW], m_t [NW];
    bit m_pend [NW][NR];
    int m_cnt [NP];
    int m_ptr;
    bit e_iv;
    int e_w, e_d, e_a, e_b, e_p, e_t;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    function automatic bit model_elig(int w);
        if (!m_v[w]) return 1'b0;
        if (m_pend[w][m_d[w]] || m_pend[w][m_a[w]] || m_pend[w][m_b[w]]) return 1'b0;
        if (m_cnt[m_p[w]] != 0) return 1'b0;
        return 1'b1;
    endfunction

    function automatic int model_pick();
        for (int k = 0; k < NW; k++) begin
            int idx;
            idx = (m_ptr + k) % NW;
            if (model_elig(idx)) return idx;
        end
        return -1;
    endfunction

    task automatic check(string tag, string what, longint got, longint exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic compare(string tag);
        longint exp_free;
        exp_free = 0;
        for (int w = 0; w < NW; w++) if (!m_v[w]) exp_free |= (longint'(1) << w);
        check(tag, "issue_valid", issue_valid, e_iv);
        if (e_iv) begin
            check(tag, "issue fields",
                  {issue_warp, issue_dst, issue_src_a, issue_src_b, issue_pipe, issue_tag},
                  {WW'(e_w), RW'(e_d), RW'(e_a), RW'(e_b), PW'(e_p), TW'(e_t)});
        end
        check(tag, "slot_free", slot_free, exp_free);
    endtask

    task automatic step(string tag, bit fv, int fw, int fd, int fa, int fb, int fp, int ft,
                        bit wv, int ww, int wr);
        int g;
        bit take;
        fetch_valid = fv;  fetch_warp = WW'(fw); fetch_dst = RW'(fd);
        fetch_src_a = RW'(fa); fetch_src_b = RW'(fb); fetch_pipe = PW'(fp); fetch_tag = TW'(ft);
        wb_valid = wv; wb_warp = WW'(ww); wb_reg = RW'(wr);
        g = model_pick();
        take = fv && (fw < NW) && (!m_v[fw] || fw == g);
        if (wv && ww < NW) m_pend[ww][wr] = 1'b0;
        for (int p = 0; p < NP; p++) if (m_cnt[p] != 0) m_cnt[p]--;
        e_iv = (g >= 0);
        if (g >= 0) begin
            e_w = g; e_d = m_d[g]; e_a = m_a[g]; e_b = m_b[g]; e_p = m_p[g]; e_t = m_t[g];
            m_pend[g][m_d[g]] = 1'b1;
            m_cnt[m_p[g]] = OCC - 1;
            m_ptr = (g + 1) % NW;
            m_v[g] = 1'b0;
        end
        if (take) begin
            m_v[fw] = 1'b1; m_d[fw] = fd; m_a[fw] = fa; m_b[fw] = fb; m_p[fw] = fp; m_t[fw] = ft;
        end
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle(string tag);
        step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic fetch(string tag, int w, int d, int a, int b, int p, int t);
        step(tag, 1, w, d, a, b, p, t, 0, 0, 0);
    endtask

    task automatic wback(string tag, int w, int r);
        step(tag, 0, 0, 0, 0, 0, 0, 0, 1, w, r);
    endtask

    function automatic bit any_pending_or_busy();
        for (int w = 0; w < NW; w++) begin
            if (m_v[w]) return 1'b1;
            for (int r = 0; r < NR; r++) if (m_pend[w][r]) return 1'b1;
        end
        return 1'b0;
    endfunction

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        for (int w = 0; w < NW; w++) begin
            m_v[w] = 0;
            for (int r = 0; r < NR; r++) m_pend[w][r] = 0;
        end
        for (int p = 0; p < NP; p++) m_cnt[p] = 0;
        m_ptr = 0; e_iv = 0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare("R1");

        // rotation among queued warps while pipe 1 is held busy
        fetch("R8", 0, 1, 0, 0, 1, 8'h01);
        fetch("R7", 20, 2, 0, 0, 1, 8'h02);
        fetch("R7", 2, 3, 0, 0, 1, 8'h03);
        fetch("R7", 10, 4, 0, 0, 1, 8'h04);
        fetch("R9", 15, 5, 0, 0, 0, 8'h05);
        repeat (10) idle("R8");

        // refill, source hazard, dropped fetch, writeback targeting
        fetch("R10", 5, 7, 0, 0, 0, 8'h10);
        fetch("R10", 5, 8, 7, 0, 0, 8'h11);
        idle("R6");
        fetch("R2", 5, 9, 0, 0, 0, 8'hEE);
        wback("R4", 4, 7);
        wback("R4", 30, 7);
        idle("R4");
        wback("R4", 5, 7);
        repeat (3) idle("R4");

        // write-after-write on register 8 of warp 5
        fetch("R5", 5, 8, 1, 1, 0, 8'h13);
        repeat (2) idle("R5");
        wback("R5", 5, 8);
        repeat (3) idle("R5");
        wback("R6", 5, 8);

        // out-of-range fetch
        fetch("R2", 26, 1, 1, 1, 0, 8'h77);
        repeat (3) idle("R11");

        // constrained random traffic
        for (int i = 0; i < 3000; i++) begin
            bit fv, wv;
            int fw, ww, wr;
            fv = ($urandom_range(0, 9) < 7);
            fw = ($urandom_range(0, 19) == 0) ? $urandom_range(NW, 31) : $urandom_range(0, NW - 1);
            wv = 0; ww = 0; wr = 0;
            if ($urandom_range(0, 9) < 4) begin
                ww = $urandom_range(0, NW - 1);
                for (int r = 0; r < NR; r++) begin
                    if (!wv && m_pend[ww][r]) begin
                        wv = 1; wr = r;
                    end
                end
            end
            step("R3", fv, fw, $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 7),
                 $urandom_range(0, NP - 1), $urandom_range(0, 255), wv, ww, wr);
        end

        // drain: release everything still pending
        for (int i = 0; i < 3000 && any_pending_or_busy(); i++) begin
            bit wv;
            int ww, wr;
            wv = 0; ww = 0; wr = 0;
            for (int w = 0; w < NW; w++) begin
                for (int r = 0; r < NR; r++) begin
                    if (!wv && m_pend[w][r]) begin
                        wv = 1; ww = w; wr = r;
                    end
                end
            end
            step("R9", 0, 0, 0, 0, 0, 0, 0, wv, ww, wr);
        end
        repeat (OCC) idle("R11");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule